// File: doc/BRIEF.md
# Line-Split Byte-Enable Generator for Load/Store Requests

This block takes a single load or store request (a byte address, a size code and up to eight bytes of store data) and turns it into byte-enable requests for a cache whose lines are LINE_BYTES wide (16 by default). The low address bits give the starting byte within the line. The size code gives the number of bytes, which can be 1, 2, 4 or 8. When the access runs past the end of its line, the block produces a second request for the following line. That request carries the bytes that spill over.

Each of the two requests has a line address, a per-byte enable mask and a valid flag. The store data is moved into the byte lanes of the line that match the enabled bytes. All other lanes are zero. The request side uses a valid/ready handshake. The results come out of one register stage and stay there until the consumer asserts ready. Load data realignment, the cache array and arbitration between several requesters are handled elsewhere.

Top module: `lsq_bytemask_split`

## Requirements
- R1: While reset is high and on the first cycle after it, lo_valid and hi_valid are 0 and req_ready is 1.
- R2: The size code maps to a byte count as follows: 00 gives 1 byte, 01 gives 2, 10 gives 4 and 11 gives 8. The number of set bits across {hi_mask, lo_mask} equals that count.
- R3: Let off be req_addr[3:0] and n the byte count. Bit i of lo_mask is set exactly when off <= i < off+n.
- R4: hi_valid is 1 only if off+n > 16, and only together with lo_valid. Bit j of hi_mask is set exactly when j < off+n-16.
- R5: lo_line equals req_addr with bits [3:0] cleared. hi_line equals lo_line+16, modulo 2^ADDR_W, so it wraps to 0 at the top of the address space.
- R6: Store byte k (req_wdata[8k+7:8k], k < n) appears in lane off+k of the 32-lane vector {hi_wdata, lo_wdata}. Lane L occupies bits [8L+7:8L].
- R7: Data lanes whose mask bit is clear are zero. Store bytes at positions k >= n have no effect on any output.
- R8: A request accepted at a clock edge (req_valid and req_ready both high) shows up on the outputs right after that edge, with lo_valid high.
- R9: While lo_valid is 1 and line_ready is 0, req_ready is 0. All outputs hold their values, and any request offered in that time is not taken.
- R10: When an output is consumed (line_ready high) and no new request is accepted at that edge, lo_valid falls to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | ADDR_W | Byte address of the access |
| req_size | input | 2 | Size code: 00=1, 01=2, 10=4, 11=8 bytes |
| req_wdata | input | 8*MAX_BYTES | Store data, byte 0 in the low bits |
| line_ready | input | 1 | Consumer takes the current output pair |
| lo_valid | output | 1 | First line request valid |
| lo_line | output | ADDR_W | Address of the line holding the start byte |
| lo_mask | output | LINE_BYTES | Byte enables for the first line |
| lo_wdata | output | 8*LINE_BYTES | Store data in first-line lanes |
| hi_valid | output | 1 | Second line request valid |
| hi_line | output | ADDR_W | Address of the following line |
| hi_mask | output | LINE_BYTES | Byte enables for the following line |
| hi_wdata | output | 8*LINE_BYTES | Store data in following-line lanes |

## Verification
The bench builds the block with its defaults: ADDR_W=32, LINE_BYTES=16 and MAX_BYTES=8. This makes the whole space of start offset and size small enough to cover every one of the 64 combinations, including every case that crosses into the next line. The 32-bit address makes it possible to start a request a few bytes below 2^32, so the second line address wraps to zero. Store data always carries random bytes above the access size, so any leak into the lanes is caught. Random stalls on line_ready exercise the hold-and-refuse behaviour.

// File: rtl/lsm_pkg.sv
`timescale 1ns/1ps
package lsm_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_HALF  = 2'b01,
        SZ_WORD  = 2'b10,
        SZ_DWORD = 2'b11
    } lsm_size_e;

    localparam int unsigned DEF_ADDR_W     = 32;
    localparam int unsigned DEF_LINE_BYTES = 16;
    localparam int unsigned DEF_MAX_BYTES  = 8;

    // byte count selected by a size code
    function automatic int unsigned size_to_bytes(input lsm_size_e code);
        return 32'd1 << code;
    endfunction

endpackage

// File: rtl/lsm_mask_gen.sv
`timescale 1ns/1ps
module lsm_mask_gen
    import lsm_pkg::*;
#(
    parameter int unsigned LINE_BYTES = DEF_LINE_BYTES
) (
    input  logic [$clog2(LINE_BYTES)-1:0] offset,
    input  lsm_size_e                     size,
    output logic [2*LINE_BYTES-1:0]       wide_mask
);
    localparam int unsigned SPAN = 2 * LINE_BYTES;

    logic [SPAN-1:0] base;
    int unsigned     nb;

    always_comb begin
        nb = size_to_bytes(size);
        for (int unsigned i = 0; i < SPAN; i++) begin
            base[i] = (i < nb);
        end
        wide_mask = base << offset;
    end
endmodule

// File: rtl/lsm_lane_shift.sv
`timescale 1ns/1ps
module lsm_lane_shift
    import lsm_pkg::*;
#(
    parameter int unsigned LINE_BYTES = DEF_LINE_BYTES,
    parameter int unsigned MAX_BYTES  = DEF_MAX_BYTES
) (
    input  logic [$clog2(LINE_BYTES)-1:0] offset,
    input  lsm_size_e                     size,
    input  logic [8*MAX_BYTES-1:0]        wdata,
    output logic [16*LINE_BYTES-1:0]      wide_data
);
    localparam int unsigned IN_W   = 8 * MAX_BYTES;
    localparam int unsigned WIDE_W = 16 * LINE_BYTES;
    localparam int unsigned OFF_W  = $clog2(LINE_BYTES);

    logic [IN_W-1:0] kept;
    int unsigned     nb;

    // drop store bytes above the access size, then slide into lanes
    always_comb begin
        nb = size_to_bytes(size);
        for (int unsigned k = 0; k < MAX_BYTES; k++) begin
            kept[k*8 +: 8] = (k < nb) ? wdata[k*8 +: 8] : 8'h00;
        end
        wide_data = {{(WIDE_W-IN_W){1'b0}}, kept} << {offset, 3'b000};
    end

    logic [OFF_W+2:0] unused_chk;
    assign unused_chk = {offset, 3'b000};
endmodule

// File: rtl/lsm_out_stage.sv
`timescale 1ns/1ps
module lsm_out_stage #(
    parameter int unsigned LINE_W = 28,
    parameter int unsigned MASK_W = 32,
    parameter int unsigned DATA_W = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [LINE_W-1:0] in_line,
    input  logic [MASK_W-1:0] in_mask,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [LINE_W-1:0] out_line,
    output logic [MASK_W-1:0] out_mask,
    output logic [DATA_W-1:0] out_data
);
    assign in_ready = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
        end else if (in_ready) begin
            out_valid <= in_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (in_ready && in_valid) begin
            out_line <= in_line;
            out_mask <= in_mask;
            out_data <= in_data;
        end
    end

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_line)
                                       && $stable(out_mask) && $stable(out_data))) // R9
        else $error("stalled output changed");
endmodule

// File: rtl/lsq_bytemask_split.sv
`timescale 1ns/1ps
module lsq_bytemask_split
    import lsm_pkg::*;
#(
    parameter int unsigned ADDR_W     = DEF_ADDR_W,
    parameter int unsigned LINE_BYTES = DEF_LINE_BYTES,
    parameter int unsigned MAX_BYTES  = DEF_MAX_BYTES
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [1:0]              req_size,
    input  logic [8*MAX_BYTES-1:0]  req_wdata,
    input  logic                    line_ready,
    output logic                    lo_valid,
    output logic [ADDR_W-1:0]       lo_line,
    output logic [LINE_BYTES-1:0]   lo_mask,
    output logic [8*LINE_BYTES-1:0] lo_wdata,
    output logic                    hi_valid,
    output logic [ADDR_W-1:0]       hi_line,
    output logic [LINE_BYTES-1:0]   hi_mask,
    output logic [8*LINE_BYTES-1:0] hi_wdata
);
    localparam int unsigned OFF_W  = $clog2(LINE_BYTES);
    localparam int unsigned LINE_W = ADDR_W - OFF_W;
    localparam int unsigned MASK_W = 2 * LINE_BYTES;
    localparam int unsigned DATA_W = 16 * LINE_BYTES;
    localparam int unsigned HALF_D = 8 * LINE_BYTES;

    lsm_size_e         size_e;
    logic [OFF_W-1:0]  offset;
    logic [MASK_W-1:0] wide_mask, mask_r;
    logic [DATA_W-1:0] wide_data, data_r;
    logic [LINE_W-1:0] line_r;

    assign size_e = lsm_size_e'(req_size);
    assign offset = req_addr[OFF_W-1:0];

    lsm_mask_gen #(.LINE_BYTES(LINE_BYTES)) u_mask (
        .offset    (offset),
        .size      (size_e),
        .wide_mask (wide_mask)
    );

    lsm_lane_shift #(.LINE_BYTES(LINE_BYTES), .MAX_BYTES(MAX_BYTES)) u_lanes (
        .offset    (offset),
        .size      (size_e),
        .wdata     (req_wdata),
        .wide_data (wide_data)
    );

    lsm_out_stage #(.LINE_W(LINE_W), .MASK_W(MASK_W), .DATA_W(DATA_W)) u_stage (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (req_valid),
        .in_ready  (req_ready),
        .in_line   (req_addr[ADDR_W-1:OFF_W]),
        .in_mask   (wide_mask),
        .in_data   (wide_data),
        .out_valid (lo_valid),
        .out_ready (line_ready),
        .out_line  (line_r),
        .out_mask  (mask_r),
        .out_data  (data_r)
    );

    assign lo_mask  = mask_r[LINE_BYTES-1:0];
    assign hi_mask  = mask_r[MASK_W-1:LINE_BYTES];
    assign lo_wdata = data_r[HALF_D-1:0];
    assign hi_wdata = data_r[DATA_W-1:HALF_D];
    assign hi_valid = lo_valid && (|hi_mask);
    assign lo_line  = {line_r, {OFF_W{1'b0}}};
    assign hi_line  = {line_r + LINE_W'(1), {OFF_W{1'b0}}};

    AST_HI_NEEDS_LO: assert property (@(posedge clk) disable iff (rst)
        hi_valid |-> lo_valid) // R4
        else $error("second line without first");

    AST_HI_LINE_NEXT: assert property (@(posedge clk) disable iff (rst)
        hi_valid |-> (hi_line == lo_line + ADDR_W'(LINE_BYTES))) // R5
        else $error("second line address wrong");

    AST_LO_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        lo_valid |-> (lo_mask != '0)) // R3
        else $error("first line mask empty");

    AST_BYTE_COUNT: assert property (@(posedge clk) disable iff (rst)
        lo_valid |-> ($countones(mask_r) == 1 || $countones(mask_r) == 2 ||
                      $countones(mask_r) == 4 || $countones(mask_r) == 8)) // R2
        else $error("mask population not a legal size");

    for (genvar g = 0; g < MASK_W; g++) begin : g_lane_chk
        AST_LANE_ZERO: assert property (@(posedge clk) disable iff (rst)
            (lo_valid && !mask_r[g]) |-> (data_r[g*8 +: 8] == 8'h00)) // R7
            else $error("disabled lane carries data");
    end
endmodule

// File: tb/tb_lsq_bytemask_split.sv
`timescale 1ns/1ps
module tb_lsq_bytemask_split;

    logic         clk = 0;
    logic         rst = 1;
    logic         req_valid = 0;
    logic         req_ready;
    logic [31:0]  req_addr = 0;
    logic [1:0]   req_size = 0;
    logic [63:0]  req_wdata = 0;
    logic         line_ready = 1;
    logic         lo_valid, hi_valid;
    logic [31:0]  lo_line, hi_line;
    logic [15:0]  lo_mask, hi_mask;
    logic [127:0] lo_wdata, hi_wdata;

    int checks = 0;
    int errors = 0;
    bit rand_stall = 0;

    always #2.5 clk = ~clk;

    lsq_bytemask_split dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .line_ready(line_ready),
        .lo_valid(lo_valid), .lo_line(lo_line), .lo_mask(lo_mask), .lo_wdata(lo_wdata),
        .hi_valid(hi_valid), .hi_line(hi_line), .hi_mask(hi_mask), .hi_wdata(hi_wdata)
    );

    typedef struct {
        logic         hv;
        int           nbytes;
        logic [31:0]  ll, hl;
        logic [15:0]  lm, hm;
        logic [127:0] ld, hd;
    } exp_t;

    exp_t sb[$];

    function automatic exp_t model(input logic [31:0] a, input logic [1:0] s,
                                   input logic [63:0] d);
        exp_t e;
        logic [31:0]  m;
        logic [255:0] v;
        int n, off;
        n = 1 << s;
        off = int'(a[3:0]);
        m = '0;
        v = '0;
        for (int i = 0; i < 32; i++) begin
            if (i >= off && i < off + n) begin
                m[i] = 1'b1;
                v[i*8 +: 8] = d[(i-off)*8 +: 8];
            end
        end
        e.nbytes = n;
        e.lm = m[15:0];
        e.hm = m[31:16];
        e.ld = v[127:0];
        e.hd = v[255:128];
        e.hv = (off + n > 16);
        e.ll = {a[31:4], 4'h0};
        e.hl = e.ll + 32'd16;
        return e;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: compare each output pair as it is taken
    always @(negedge clk) begin
        if (!rst && lo_valid && line_ready) begin
            if (sb.size() == 0) begin
                chk(0, "R8 unexpected output", 128'(lo_mask), 128'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(lo_mask == e.lm, "R3 lo_mask", 128'(lo_mask), 128'(e.lm));
                chk(hi_valid == e.hv, "R4 hi_valid", 128'(hi_valid), 128'(e.hv));
                if (e.hv)
                    chk(hi_mask == e.hm, "R4 hi_mask", 128'(hi_mask), 128'(e.hm));
                chk($countones({hi_mask, lo_mask}) == e.nbytes, "R2 byte count",
                    128'($countones({hi_mask, lo_mask})), 128'(e.nbytes));
                chk(lo_line == e.ll, "R5 lo_line", 128'(lo_line), 128'(e.ll));
                if (e.hv)
                    chk(hi_line == e.hl, "R5 hi_line", 128'(hi_line), 128'(e.hl));
                chk(lo_wdata == e.ld, "R6 R7 lo_wdata", lo_wdata, e.ld);
                chk(hi_wdata == e.hd, "R6 R7 hi_wdata", hi_wdata, e.hd);
            end
        end
    end

    // random backpressure when enabled
    always @(posedge clk) begin
        if (rand_stall) begin
            #1 line_ready = ($urandom_range(0, 2) != 0);
        end
    end

    task automatic send(input logic [31:0] a, input logic [1:0] s, input logic [63:0] d);
        bit acc;
        sb.push_back(model(a, s, d));
        req_valid = 1; req_addr = a; req_size = s; req_wdata = d;
        acc = 0;
        while (!acc) begin
            @(negedge clk);
            acc = req_ready;
            @(posedge clk); #1;
        end
        req_valid = 0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #1000000;
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        exp_t ea;
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!lo_valid && !hi_valid, "R1 valid in reset", 128'({lo_valid, hi_valid}), 128'h0);
        chk(req_ready, "R1 ready in reset", 128'(req_ready), 128'h1);
        @(posedge clk); #1 rst = 0;
        @(negedge clk);
        chk(!lo_valid && !hi_valid, "R1 valid after reset", 128'({lo_valid, hi_valid}), 128'h0);
        chk(req_ready, "R1 ready after reset", 128'(req_ready), 128'h1);
        @(posedge clk); #1;

        // R8 latency, R10 drop
        send(32'h0000_1003, 2'b01, 64'hFFEE_DDCC_BBAA_1234);
        chk(lo_valid, "R8 output right after accept", 128'(lo_valid), 128'h1);
        @(posedge clk); #1;
        chk(!lo_valid, "R10 valid drops when idle", 128'(lo_valid), 128'h0);

        // every offset and size, with garbage in unused store bytes (R7)
        for (int s = 0; s < 4; s++) begin
            for (int o = 0; o < 16; o++) begin
                send({$urandom_range(0, 32'h0FFF_FFFF), 4'(o)}, 2'(s),
                     {$urandom, $urandom});
            end
        end

        // R5 wrap at top of address space
        send(32'hFFFF_FFFC, 2'b11, 64'h8877_6655_4433_2211);
        send(32'hFFFF_FFF0, 2'b11, 64'h0102_0304_0506_0708);

        // R9 stall: outputs hold, new request refused
        @(posedge clk); #1;
        line_ready = 0;
        ea = model(32'h0000_200E, 2'b10, 64'h1111_2222_3333_4444);
        send(32'h0000_200E, 2'b10, 64'h1111_2222_3333_4444);
        sb.push_back(model(32'h0000_3005, 2'b11, 64'hAAAA_BBBB_CCCC_DDDD));
        req_valid = 1; req_addr = 32'h0000_3005; req_size = 2'b11;
        req_wdata = 64'hAAAA_BBBB_CCCC_DDDD;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk(!req_ready, "R9 ready low while stalled", 128'(req_ready), 128'h0);
            chk(lo_mask == ea.lm && hi_mask == ea.hm && lo_wdata == ea.ld,
                "R9 outputs held", 128'({hi_mask, lo_mask}), 128'({ea.hm, ea.lm}));
        end
        @(posedge clk); #1;
        line_ready = 1;
        @(negedge clk);
        chk(req_ready, "R9 ready returns", 128'(req_ready), 128'h1);
        @(posedge clk); #1;
        req_valid = 0;

        // random traffic with random backpressure
        rand_stall = 1;
        for (int t = 0; t < 300; t++) begin
            send($urandom, 2'($urandom_range(0, 3)), {$urandom, $urandom});
            if ($urandom_range(0, 3) == 0) begin
                @(posedge clk); #1;
            end
        end
        rand_stall = 0;
        @(posedge clk); #1 line_ready = 1;
        repeat (4) @(posedge clk);
        #1;
        chk(sb.size() == 0, "R8 all requests produced", 128'(sb.size()), 128'h0);
        chk(!lo_valid, "R10 idle at end", 128'(lo_valid), 128'h0);
        finish_run();
    end
endmodule